// File: doc/BRIEF.md
# Elastic Single-Track Token Pipeline

This block is a cycle-based model of a self-timed linear pipeline. A chain of storage links holds data items. Each link keeps one shared occupancy bit: its upstream neighbour sets the bit when it hands an item over, and its downstream neighbour clears it when it takes the item. A stage between two links fires only when the link before it holds an item and the link after it is free. A firing moves the bundled data word forward, marks the destination occupied and frees the source, all on one clock edge. Link storage keeps its value except during a firing.

Items enter at the head whenever the first link is free and leave at the tail whenever the last link is occupied, so the occupancy is elastic. A mode input joins the last link back to the first. A closed ring can then be loaded with a chosen number of tokens, and the firing counter measures throughput against occupancy. The per-link occupancy vector is brought out for observation.

Top module: `erp_pipeline`

## Requirements
- R1: After reset every link is free: `link_full` is all zeros, `in_ready` is 1, `out_valid` is 0 and `fire_count` is 0.
- R2: For k in 1..N_LINKS-1, stage k fires on a clock edge exactly when link k-1 is occupied and link k is free before that edge. All stages are evaluated on the same edge. After a firing, link k holds the data that link k-1 held, link k is occupied and link k-1 is free. Bit k of `link_full` reports link k.
- R3: `in_ready` equals NOT `link_full[0]`. When `in_valid` and `in_ready` are both 1 at an edge, `in_data` is stored in link 0 and link 0 becomes occupied. `in_valid` while `in_ready` is 0 has no effect.
- R4: `out_valid` is 1 exactly when the last link is occupied and `loop_closed` is 0, and `out_data` is the word in the last link. `out_take` while `out_valid` is 1 frees the last link at that edge. `out_take` while `out_valid` is 0 has no effect.
- R5: Items leave in the order they entered. A stored word changes only when its link is filled.
- R6: An item inserted into an empty open pipeline raises `out_valid` N_LINKS-1 edges after its insertion edge. With the source always valid and the sink always taking, the head accepts exactly one item every two cycles.
- R7: With `loop_closed` at 1, a wrap stage moves the last link into link 0 when the last link is occupied, link 0 is free and `in_valid` is 0. Insertion takes priority over the wrap. Withdrawal is disabled, and without an insertion the number of occupied links does not change.
- R8: `fire_count` advances on each edge by the number of stage firings on that edge, wrap stage included, modulo 2^CNT_W. Insertions and withdrawals are not counted. An item that passes through an open pipeline adds N_LINKS-1.
- R9: In a closed ring, one token and N_LINKS-1 tokens each give exactly one firing per cycle. A fully occupied ring gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loop_closed | input | 1 | 1 joins the last link back to link 0 |
| in_valid | input | 1 | Head offers an item |
| in_data | input | DW | Head data word |
| in_ready | output | 1 | Link 0 free, insertion possible |
| out_valid | output | 1 | Tail item available |
| out_data | output | DW | Data word in the last link |
| out_take | input | 1 | Tail consumer takes the item |
| link_full | output | N_LINKS | Occupancy bit of every link |
| fire_count | output | CNT_W | Running count of stage firings |

## Verification
The bench measures the empty-pipe latency edge by edge. A design that let a stage fire on a link freed in the same cycle would deliver too early and would also break the two-cycle streaming rate. It fills the pipeline against a stalled sink and then offers an extra item: a head that ignored occupancy would overwrite a word, and the scoreboard would see a missing or foreign item. In a closed ring it measures firings per cycle with one token, with N_LINKS-1 tokens and with a full ring. A wrong wrap condition or a wrong insertion priority shows up as a wrong firing count or as lost or duplicated tokens. It also pulses the tail take while nothing is offered and checks that no token disappears.

// File: rtl/erp_pkg.sv
package erp_pkg;

  // Single AND condition of a stage: source occupied, destination free.
  function automatic logic may_fire(input logic pred_full,
                                    input logic succ_full,
                                    input logic enable);
    return enable & pred_full & ~succ_full;
  endfunction

  // Head acceptance: the first link must be free.
  function automatic logic head_open(input logic first_full);
    return ~first_full;
  endfunction

  // Tail offer: last link occupied and ring not closed.
  function automatic logic tail_offer(input logic last_full,
                                      input logic closed);
    return last_full & ~closed;
  endfunction

endpackage

// File: rtl/erp_link_cell.sv
module erp_link_cell #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill,
  input  logic          drain,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic [DW-1:0] dout
);

  // Shared occupancy bit: set by the sender, cleared by the receiver.
  always_ff @(posedge clk) begin
    if (rst)        full <= 1'b0;
    else if (fill)  full <= 1'b1;
    else if (drain) full <= 1'b0;
  end

  // Normally closed storage: captures only on a fill.
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (fill) dout <= din;
  end

  AST_FILL_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
    fill |-> !full); // R2
  AST_DRAIN_NEEDS_ITEM: assert property (@(posedge clk) disable iff (rst)
    drain |-> full); // R2
  AST_STORE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !fill |=> $stable(dout)); // R5

endmodule

// File: rtl/erp_stage_gate.sv
module erp_stage_gate (
  input  logic pred_full,
  input  logic succ_full,
  input  logic enable,
  output logic fire
);

  assign fire = erp_pkg::may_fire(pred_full, succ_full, enable);

endmodule

// File: rtl/erp_fire_tally.sv
module erp_fire_tally #(
  parameter int NF    = 11,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF-1:0]    fire,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] step;

  always_comb step = CNT_W'($countones(fire));

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + step;
  end

  AST_TALLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fire == '0) |=> $stable(count)); // R8

endmodule

// File: rtl/erp_pipeline.sv
module erp_pipeline #(
  parameter int N_LINKS = 11,
  parameter int DW      = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loop_closed,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [DW-1:0]      out_data,
  input  logic               out_take,
  output logic [N_LINKS-1:0] link_full,
  output logic [CNT_W-1:0]   fire_count
);

  localparam int LAST = N_LINKS - 1;

  // Named internal events
  logic [N_LINKS-1:0] fire;      // fire[0] = wrap stage, fire[k] = stage k
  logic [N_LINKS-1:0] fill;
  logic [N_LINKS-1:0] drain;
  logic               ins_go;
  logic               out_go;
  logic               wrap_en;
  logic [DW-1:0]      ldata [N_LINKS];
  logic [DW-1:0]      ldin  [N_LINKS];

  // Head and tail
  assign in_ready  = erp_pkg::head_open(link_full[0]);
  assign ins_go    = in_valid & in_ready;
  assign out_valid = erp_pkg::tail_offer(link_full[LAST], loop_closed);
  assign out_go    = out_take & out_valid;
  assign out_data  = ldata[LAST];
  assign wrap_en   = loop_closed & ~in_valid;

  // Wrap stage: last link into link 0
  erp_stage_gate u_wrap (
    .pred_full (link_full[LAST]),
    .succ_full (link_full[0]),
    .enable    (wrap_en),
    .fire      (fire[0])
  );

  genvar k;
  generate
    for (k = 1; k < N_LINKS; k++) begin : g_stage
      erp_stage_gate u_gate (
        .pred_full (link_full[k-1]),
        .succ_full (link_full[k]),
        .enable    (1'b1),
        .fire      (fire[k])
      );
      AST_FIRE_ATOMIC: assert property (@(posedge clk) disable iff (rst)
        fire[k] |=> (link_full[k] && !link_full[k-1] &&
                     ldata[k] == $past(ldata[k-1]))); // R2
    end

    for (k = 0; k < N_LINKS; k++) begin : g_link
      if (k == 0) begin : g_head
        assign fill[k] = ins_go | fire[0];
        assign ldin[k] = ins_go ? in_data : ldata[LAST];
      end else begin : g_body
        assign fill[k] = fire[k];
        assign ldin[k] = ldata[k-1];
      end
      if (k == LAST) begin : g_tail
        assign drain[k] = fire[0] | out_go;
      end else begin : g_mid
        assign drain[k] = fire[k+1];
      end
      erp_link_cell #(.DW(DW)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .fill  (fill[k]),
        .drain (drain[k]),
        .din   (ldin[k]),
        .full  (link_full[k]),
        .dout  (ldata[k])
      );
    end
  endgenerate

  erp_fire_tally #(.NF(N_LINKS), .CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .count (fire_count)
  );

  AST_INS_LANDS: assert property (@(posedge clk) disable iff (rst)
    ins_go |=> (link_full[0] && ldata[0] == $past(in_data))); // R3
  AST_RING_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    (loop_closed && !ins_go) |=>
      ($countones(link_full) == $past($countones(link_full)))); // R7
  AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    out_go |=> !link_full[LAST]); // R4

endmodule

// File: tb/tb_erp_pipeline.sv
module tb_erp_pipeline;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 11;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loop_closed = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;
  logic out_take = 1'b0;
  logic [N-1:0] link_full;
  logic [CW-1:0] fire_count;

  erp_pipeline #(.N_LINKS(N), .DW(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .loop_closed(loop_closed),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_take(out_take),
    .link_full(link_full), .fire_count(fire_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int popped = 0;
  logic take_en = 1'b0;
  logic take_force = 1'b0;
  logic sb_on = 1'b1;
  logic [DW-1:0] q[$];
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Driver: offer one item, wait for acceptance, record it as expected.
  task automatic send(input logic [DW-1:0] v);
    in_valid = 1'b1;
    in_data  = v;
    while (!in_ready) @(negedge clk);
    q.push_back(v);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: takes tail items and compares them with the scoreboard (R5).
  always @(negedge clk) begin
    #1;
    if (rst) begin
      out_take = 1'b0;
    end else begin
      if (take_en && out_valid) begin
        popped++;
        if (sb_on) begin
          if (q.size() == 0) begin
            check(1'b0, "R5 unexpected item", int'(out_data), -1);
          end else begin
            logic [DW-1:0] e;
            e = q.pop_front();
            check(out_data == e, "R5 order", int'(out_data), int'(e));
          end
        end
      end
      out_take = take_force | (take_en & out_valid);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int c0, p0, acc;
    bit prev_acc;
    logic [DW-1:0] v;

    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    check(link_full == '0, "R1 links", int'(link_full), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(fire_count == '0, "R1 fire_count", int'(fire_count), 0);

    // Latency through an empty open pipe (R6) and firing tally (R8)
    c0 = int'(fire_count);
    send(8'h10);
    cycles(N-2);
    check(out_valid == 1'b0, "R6 not before N-1 edges", int'(out_valid), 0);
    cycles(1);
    check(out_valid == 1'b1, "R6 valid after N-1 edges", int'(out_valid), 1);
    check(out_data == 8'h10, "R4 out_data", int'(out_data), 16);
    check(link_full == N'(1) << (N-1), "R2 token at last link", int'(link_full), 1 << (N-1));
    check(((int'(fire_count) - c0) & 8'hFF) == N-1, "R8 fires per passage",
          (int'(fire_count) - c0) & 8'hFF, N-1);
    take_en = 1'b1;
    cycles(3);
    check(link_full == '0, "R4 take frees tail", int'(link_full), 0);

    // Streaming rate (R6)
    acc = 0; prev_acc = 0; v = 8'h20;
    for (int i = 0; i < 40; i++) begin
      in_valid = 1'b1;
      in_data  = v;
      if (in_ready) begin
        if (prev_acc) check(1'b0, "R6 back-to-back accept", 1, 0);
        q.push_back(v);
        v = v + 1;
        acc++;
        prev_acc = 1;
      end else begin
        prev_acc = 0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(acc == 20, "R6 one item per two cycles", acc, 20);
    cycles(2*N);
    check(q.size() == 0, "R5 stream drained", q.size(), 0);
    check(link_full == '0, "R5 stream empty", int'(link_full), 0);

    // Backpressure fill, then ignored insert (R2, R3)
    take_en = 1'b0;
    for (int i = 0; i < N; i++) send(8'h40 + 8'(i));
    cycles(N);
    check(link_full == '1, "R2 compacted full", int'(link_full), (1 << N) - 1);
    check(in_ready == 1'b0, "R3 not ready when full", int'(in_ready), 0);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    for (int i = 0; i < 3; i++) begin
      check(in_ready == 1'b0, "R3 ready low", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    p0 = popped;
    take_en = 1'b1;
    cycles(3*N);
    check(popped - p0 == N, "R3 ignored item not stored", popped - p0, N);
    check(q.size() == 0, "R5 all items out", q.size(), 0);
    check(link_full == '0, "R3 empty after drain", int'(link_full), 0);

    // Ring with one token (R9, R7, R4)
    take_en = 1'b0;
    send(8'h55);
    cycles(N);
    loop_closed = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 no offer in ring", int'(out_valid), 0);
    c0 = int'(fire_count);
    cycles(30);
    check(((int'(fire_count) - c0) & 8'hFF) == 30, "R9 one token rate",
          (int'(fire_count) - c0) & 8'hFF, 30);
    check($countones(link_full) == 1, "R7 one token kept", $countones(link_full), 1);
    take_force = 1'b1;
    cycles(2);
    take_force = 1'b0;
    cycles(1);
    check($countones(link_full) == 1, "R4 take ignored in ring", $countones(link_full), 1);
    loop_closed = 1'b0;
    take_en = 1'b1;
    cycles(2*N);
    check(q.size() == 0 && link_full == '0, "R5 ring token out", q.size(), 0);

    // Ring with N-1 tokens (R9)
    take_en = 1'b0;
    for (int i = 0; i < N-1; i++) send(8'h60 + 8'(i));
    cycles(N);
    check(link_full == {{(N-1){1'b1}}, 1'b0}, "R2 N-1 compacted",
          int'(link_full), ((1 << N) - 1) & ~1);
    loop_closed = 1'b1;
    @(negedge clk);
    c0 = int'(fire_count);
    cycles(30);
    check(((int'(fire_count) - c0) & 8'hFF) == 30, "R9 one hole rate",
          (int'(fire_count) - c0) & 8'hFF, 30);
    check($countones(link_full) == N-1, "R7 tokens kept", $countones(link_full), N-1);

    // Insertion priority over wrap, then deadlock (R7, R9)
    in_valid = 1'b1;
    in_data  = 8'hAA;
    for (int i = 0; i < 4*N && !in_ready; i++) @(negedge clk);
    check(in_ready == 1'b1, "R7 hole reaches head", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check($countones(link_full) == N, "R7 insertion wins", $countones(link_full), N);
    c0 = int'(fire_count);
    cycles(10);
    check(((int'(fire_count) - c0) & 8'hFF) == 0, "R9 full ring still",
          (int'(fire_count) - c0) & 8'hFF, 0);
    take_force = 1'b1;
    cycles(2);
    take_force = 1'b0;
    cycles(1);
    check(link_full == '1, "R4 take ignored when not offered", int'(link_full), (1 << N) - 1);
    loop_closed = 1'b0;
    q.delete();
    sb_on = 1'b0;
    p0 = popped;
    take_en = 1'b1;
    cycles(3*N);
    check(popped - p0 == N, "R7 all ring tokens released", popped - p0, N);
    check(link_full == '0, "R7 ring drained", int'(link_full), 0);

    finish_up();
  end

endmodule